// File: doc/BRIEF.md
# Register Rename Stage

This block turns one decoded instruction per cycle from architectural register names into physical register names. An alias table holds the current physical register for every architectural register. Instructions that produce a value take a fresh physical register from the head of a FIFO free list, and the destination's alias entry is pointed at it. Source fields are read through the table before the instruction's own update, so each instruction sees the newest producer of each operand. Every accepted instruction also sends one allocation to the reorder buffer. That allocation carries the architectural destination, the new physical destination and the mapping it replaces, which commit later hands back for release.

Two kinds of instruction are resolved by remapping alone. They are flagged as not needing execution, and their reorder-buffer entries are marked ready at allocation. The first is an XOR whose two sources name the same register: its destination is bound to a reserved physical register that always reads zero. The second is a register move: its destination is aliased to the source's current physical register. A physical register that is shared through moves carries a reference count. It goes back to the free list only when its last mapping is released.

A two-state controller sequences the block. ST_SEED is entered at reset and pushes one spare physical register per cycle into the free list. The transition seed_done moves it to ST_RUN after the last spare has been pushed. ST_RUN renames instructions and stays there until the next reset.

Top module: `rn_stage`

## Requirements
- R1: Reset maps architectural register i to physical register i. The block then stays in ST_SEED with stall high for exactly NUM_PHYS-NUM_ARCH-1 cycles, and in that time it loads physical registers NUM_ARCH up to NUM_PHYS-2 into the free list in ascending order.
- R2: An instruction of kind ALU (in_op=0), or an XOR (in_op=1) whose sources differ, takes the free-list head as its physical destination and rebinds its destination register to it. out_exec is 1.
- R3: Physical sources are looked up before the same instruction's destination update, so an instruction reads the mapping written by the newest earlier accepted instruction.
- R4: An XOR with in_src1 equal to in_src2 binds the destination to the zero register NUM_PHYS-1. It takes nothing from the free list and drives out_exec to 0.
- R5: A move (in_op=2) binds the destination to in_src1's current physical register. It takes nothing from the free list and drives out_exec to 0.
- R6: Each accepted instruction raises rob_alloc with rob_arch=in_dst, rob_pdst equal to the new physical destination and rob_pold equal to the mapping it replaced. A no-destination instruction (in_op=3) reports NUM_PHYS-1 in both fields and leaves the table unchanged.
- R7: rob_ready is 1 for zeroing XORs and moves, and 0 for every other kind.
- R8: stall is high while rob_full is high. It is also high when the instruction needs a fresh register and the free list is empty. Moves, zeroing XORs and no-destination instructions still proceed when the free list is empty.
- R9: Each rel_valid pulse removes one mapping from rel_preg. When its count reaches zero, the register is appended to the free-list tail and can be taken from the following cycle. Releasing NUM_PHYS-1 has no effect.
- R10: All rename and allocation outputs are registered and appear on the clock edge that accepts the instruction (accept = in_valid and not stall). out_valid and rob_alloc are 0 in every other cycle and during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_op | input | 2 | Kind: 0 ALU, 1 XOR, 2 move, 3 no destination |
| in_dst | input | AW | Architectural destination |
| in_src1 | input | AW | Architectural source 1 |
| in_src2 | input | AW | Architectural source 2 |
| rob_full | input | 1 | Reorder buffer cannot take an entry |
| rel_valid | input | 1 | Commit releases one mapping |
| rel_preg | input | PW | Physical register being released |
| stall | output | 1 | Instruction not accepted this cycle |
| out_valid | output | 1 | Renamed instruction valid |
| out_op | output | 2 | Kind of the renamed instruction |
| out_exec | output | 1 | Instruction needs an execution unit |
| out_pdst | output | PW | Physical destination |
| out_psrc1 | output | PW | Physical source 1 |
| out_psrc2 | output | PW | Physical source 2 |
| rob_alloc | output | 1 | Reorder-buffer allocation request |
| rob_arch | output | AW | Architectural destination of the entry |
| rob_pdst | output | PW | New physical destination of the entry |
| rob_pold | output | PW | Replaced physical mapping, for release at commit |
| rob_ready | output | 1 | Entry is complete at allocation |

## Verification
stall is combinational and is due in the same cycle as the inputs. The bench therefore drives each instruction just after a falling edge and compares stall a short settle time later. Rename and allocation results are due at the next rising edge, and the bench compares them at the falling edge that follows. A register freed by a release can first be taken one cycle after the release edge, and the bench's free-list queue applies pops before pushes to match this. Seeding is checked by counting falling edges from reset release until stall drops.

// File: rtl/rn_pkg.sv
package rn_pkg;

    typedef enum logic [1:0] {
        OPK_ALU   = 2'd0,
        OPK_XOR   = 2'd1,
        OPK_MOV   = 2'd2,
        OPK_NODST = 2'd3
    } opk_e;

    typedef enum logic {
        ST_SEED = 1'b0,
        ST_RUN  = 1'b1
    } rn_state_e;

endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
    parameter int PW    = 4,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [PW-1:0] push_data,
    input  logic          pop,
    output logic [PW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int IW = $clog2(DEPTH);

    logic [PW-1:0] slots [DEPTH];
    logic [IW:0]   wr_ptr;
    logic [IW:0]   rd_ptr;

    assign empty = (wr_ptr == rd_ptr);
    assign full  = (wr_ptr[IW] != rd_ptr[IW]) && (wr_ptr[IW-1:0] == rd_ptr[IW-1:0]);
    assign head  = slots[rd_ptr[IW-1:0]];

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr[IW-1:0]] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // A push into a full list would lose a register (R9)
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // A pop from an empty list would hand out a stale register (R8)
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/rn_alias.sv
module rn_alias #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16,
    parameter int AW       = $clog2(NUM_ARCH),
    parameter int PW       = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a1,
    input  logic [AW-1:0] rd_a2,
    input  logic [AW-1:0] rd_ad,
    output logic [PW-1:0] rd_p1,
    output logic [PW-1:0] rd_p2,
    output logic [PW-1:0] rd_pd,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_arch,
    input  logic [PW-1:0] wr_preg,
    input  logic          inc_en,
    input  logic          inc_fresh,
    input  logic [PW-1:0] inc_preg,
    input  logic          dec_en,
    input  logic [PW-1:0] dec_preg,
    output logic          freed
);
    localparam int            CW      = $clog2(NUM_ARCH + 2);
    localparam logic [PW-1:0] ZP      = PW'(NUM_PHYS - 1);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [PW-1:0] amap [NUM_ARCH];
    logic [CW-1:0] refs [NUM_PHYS];
    logic          inc_live;
    logic          dec_live;

    assign rd_p1 = amap[rd_a1];
    assign rd_p2 = amap[rd_a2];
    assign rd_pd = amap[rd_ad];

    assign inc_live = inc_en && (inc_preg != ZP);
    assign dec_live = dec_en && (dec_preg != ZP);
    assign freed    = dec_live && (refs[dec_preg] == CW'(1))
                      && !(inc_live && (inc_preg == dec_preg));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                amap[i] <= PW'(i);
            end
        end else if (wr_en) begin
            amap[wr_arch] <= wr_preg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PHYS; p++) begin
                refs[p] <= (p < NUM_ARCH) ? CW'(1) : '0;
            end
        end else begin
            for (int p = 0; p < NUM_PHYS; p++) begin
                if (inc_live && (inc_preg == PW'(p)) && !(dec_live && (dec_preg == PW'(p)))) begin
                    refs[p] <= refs[p] + 1'b1;
                end else if (dec_live && (dec_preg == PW'(p)) && !(inc_live && (inc_preg == PW'(p)))) begin
                    refs[p] <= refs[p] - 1'b1;
                end
            end
        end
    end

    // A register popped from the free list must hold no mapping (R2)
    assert_fresh_alloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && inc_fresh) |-> (refs[inc_preg] == '0));

    // A release must name a register that still has a mapping (R9)
    assert_live_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_live |-> (refs[dec_preg] != '0));

    // Sharing through moves must not wrap a count (R9)
    assert_count_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inc_live |-> (refs[inc_preg] != CNT_MAX));

endmodule

// File: rtl/rn_stage.sv
module rn_stage #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16,
    parameter int AW       = $clog2(NUM_ARCH),
    parameter int PW       = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    in_op,
    input  logic [AW-1:0] in_dst,
    input  logic [AW-1:0] in_src1,
    input  logic [AW-1:0] in_src2,
    input  logic          rob_full,
    input  logic          rel_valid,
    input  logic [PW-1:0] rel_preg,
    output logic          stall,
    output logic          out_valid,
    output logic [1:0]    out_op,
    output logic          out_exec,
    output logic [PW-1:0] out_pdst,
    output logic [PW-1:0] out_psrc1,
    output logic [PW-1:0] out_psrc2,
    output logic          rob_alloc,
    output logic [AW-1:0] rob_arch,
    output logic [PW-1:0] rob_pdst,
    output logic [PW-1:0] rob_pold,
    output logic          rob_ready
);
    import rn_pkg::*;

    localparam logic [PW-1:0] ZERO_PREG = PW'(NUM_PHYS - 1);
    localparam logic [PW-1:0] SEED_LO   = PW'(NUM_ARCH);
    localparam logic [PW-1:0] SEED_HI   = PW'(NUM_PHYS - 2);

    rn_state_e     state, state_nx;
    logic [PW-1:0] seed_idx;

    opk_e          kind;
    logic          is_zero, is_move, needs_reg, has_dst, elim, accept;
    logic [PW-1:0] p_src1, p_src2, p_dst_old, new_pdst;

    logic          fl_push, fl_pop, fl_empty, fl_full;
    logic [PW-1:0] fl_push_data, fl_head;
    logic          rel_freed;

    // ---------------- decode of the incoming instruction ----------------
    always_comb begin
        kind      = opk_e'(in_op);
        is_zero   = (kind == OPK_XOR) && (in_src1 == in_src2);
        is_move   = (kind == OPK_MOV);
        needs_reg = (kind == OPK_ALU) || ((kind == OPK_XOR) && !is_zero);
        has_dst   = (kind != OPK_NODST);
        elim      = is_zero || is_move;
    end

    always_comb begin
        stall  = (state != ST_RUN) || rob_full || (needs_reg && fl_empty);
        accept = in_valid && !stall;
        fl_pop = accept && needs_reg;
    end

    always_comb begin
        if (needs_reg) begin
            new_pdst = fl_head;
        end else if (is_move) begin
            new_pdst = p_src1;
        end else begin
            new_pdst = ZERO_PREG;
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_SEED;
            seed_idx <= SEED_LO;
        end else begin
            state <= state_nx;
            if (state == ST_SEED) begin
                seed_idx <= seed_idx + 1'b1;
            end
        end
    end

    always_comb begin
        state_nx     = state;
        fl_push      = 1'b0;
        fl_push_data = rel_preg;
        unique case (state)
            ST_SEED: begin
                fl_push      = 1'b1;
                fl_push_data = seed_idx;
                if (seed_idx == SEED_HI) begin
                    state_nx = ST_RUN;
                end
            end
            ST_RUN: begin
                fl_push      = rel_freed;
                fl_push_data = rel_preg;
            end
            default: state_nx = ST_SEED;
        endcase
    end

    // ---------------- storage ----------------
    rn_freelist #(
        .PW    (PW),
        .DEPTH (NUM_PHYS)
    ) u_freelist (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fl_push),
        .push_data (fl_push_data),
        .pop       (fl_pop),
        .head      (fl_head),
        .empty     (fl_empty),
        .full      (fl_full)
    );

    rn_alias #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_PHYS (NUM_PHYS),
        .AW       (AW),
        .PW       (PW)
    ) u_alias (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a1     (in_src1),
        .rd_a2     (in_src2),
        .rd_ad     (in_dst),
        .rd_p1     (p_src1),
        .rd_p2     (p_src2),
        .rd_pd     (p_dst_old),
        .wr_en     (accept && has_dst),
        .wr_arch   (in_dst),
        .wr_preg   (new_pdst),
        .inc_en    (accept && (needs_reg || is_move)),
        .inc_fresh (fl_pop),
        .inc_preg  (new_pdst),
        .dec_en    (rel_valid),
        .dec_preg  (rel_preg),
        .freed     (rel_freed)
    );

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            rob_alloc <= 1'b0;
            out_op    <= '0;
            out_exec  <= 1'b0;
            out_pdst  <= '0;
            out_psrc1 <= '0;
            out_psrc2 <= '0;
            rob_arch  <= '0;
            rob_pdst  <= '0;
            rob_pold  <= '0;
            rob_ready <= 1'b0;
        end else begin
            out_valid <= accept;
            rob_alloc <= accept;
            if (accept) begin
                out_op    <= in_op;
                out_exec  <= !elim;
                out_pdst  <= new_pdst;
                out_psrc1 <= p_src1;
                out_psrc2 <= p_src2;
                rob_arch  <= in_dst;
                rob_pdst  <= new_pdst;
                rob_pold  <= has_dst ? p_dst_old : ZERO_PREG;
                rob_ready <= elim;
            end
        end
    end

    // Nothing is renamed while the free list is being seeded (R1)
    assert_seed_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEED) |=> !out_valid);

    // Commit has nothing to release before renaming starts (R9)
    assert_no_release_seed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEED) |-> !rel_valid);

    // A full reorder buffer blocks the next allocation (R8)
    assert_full_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rob_full |=> !rob_alloc);

    // The zero register never circulates through the free list (R4)
    assert_zero_not_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fl_pop |-> (fl_head != ZERO_PREG));

    // Entries complete at allocation never go to execution (R5)
    assert_ready_no_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rob_ready) |-> !out_exec);

endmodule

// File: tb/rn_stage_tb.sv
module rn_stage_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NA = 8;
    localparam int NP = 16;
    localparam int AW = 3;
    localparam int PW = 4;
    localparam int ZP = NP - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_op = '0;
    logic [AW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic          rob_full = 1'b0;
    logic          rel_valid = 1'b0;
    logic [PW-1:0] rel_preg = '0;
    logic          stall, out_valid, out_exec, rob_alloc, rob_ready;
    logic [1:0]    out_op;
    logic [PW-1:0] out_pdst, out_psrc1, out_psrc2, rob_pdst, rob_pold;
    logic [AW-1:0] rob_arch;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rn_stage #(.NUM_ARCH(NA), .NUM_PHYS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .rob_full(rob_full), .rel_valid(rel_valid), .rel_preg(rel_preg),
        .stall(stall), .out_valid(out_valid), .out_op(out_op), .out_exec(out_exec),
        .out_pdst(out_pdst), .out_psrc1(out_psrc1), .out_psrc2(out_psrc2),
        .rob_alloc(rob_alloc), .rob_arch(rob_arch), .rob_pdst(rob_pdst),
        .rob_pold(rob_pold), .rob_ready(rob_ready)
    );

    int checks = 0;
    int errors = 0;

    // bench-side model of the mapping state
    int mmap [NA];
    int mcnt [NP];
    bit recyc [NP];
    int mfree [$];
    int robq  [$];

    // expectation for the next registered output
    bit pend = 0;
    int e_op, e_pd, e_p1, e_p2, e_po, e_arch;
    bit e_exec, e_ready, e_recyc, e_zero, e_move, e_needs;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk(out_valid === pend, "R10", int'(out_valid), int'(pend));
        chk(rob_alloc === pend, "R6", int'(rob_alloc), int'(pend));
        if (pend) begin
            if (e_recyc)      chk(out_pdst == PW'(e_pd), "R9", int'(out_pdst), e_pd);
            else if (e_needs) chk(out_pdst == PW'(e_pd), "R2", int'(out_pdst), e_pd);
            else if (e_zero)  chk(out_pdst == PW'(e_pd), "R4", int'(out_pdst), e_pd);
            else if (e_move)  chk(out_pdst == PW'(e_pd), "R5", int'(out_pdst), e_pd);
            else              chk(out_pdst == PW'(e_pd), "R6", int'(out_pdst), e_pd);
            if (e_p1 >= NA) chk(out_psrc1 == PW'(e_p1), "R3", int'(out_psrc1), e_p1);
            else            chk(out_psrc1 == PW'(e_p1), "R1", int'(out_psrc1), e_p1);
            if (e_p2 >= NA) chk(out_psrc2 == PW'(e_p2), "R3", int'(out_psrc2), e_p2);
            else            chk(out_psrc2 == PW'(e_p2), "R1", int'(out_psrc2), e_p2);
            if (e_zero)      chk(out_exec == e_exec, "R4", int'(out_exec), int'(e_exec));
            else if (e_move) chk(out_exec == e_exec, "R5", int'(out_exec), int'(e_exec));
            else             chk(out_exec == e_exec, "R2", int'(out_exec), int'(e_exec));
            chk(out_op == 2'(e_op), "R10", int'(out_op), e_op);
            chk(rob_arch == AW'(e_arch), "R6", int'(rob_arch), e_arch);
            chk(rob_pdst == PW'(e_pd), "R6", int'(rob_pdst), e_pd);
            chk(rob_pold == PW'(e_po), "R6", int'(rob_pold), e_po);
            chk(rob_ready == e_ready, "R7", int'(rob_ready), int'(e_ready));
        end
    endtask

    // one cycle: check last results, drive, check stall, update the model
    task automatic cyc(input bit v, input int op, input int d, input int s1, input int s2,
                       input bit full, input bit commit);
        bit relv, zero, move, needs, hasd, xstall;
        int relp;
        @(negedge clk);
        check_outputs();
        relv = commit && (robq.size() > 0);
        relp = relv ? robq.pop_front() : 0;
        in_valid  = v;
        in_op     = 2'(op);
        in_dst    = AW'(d);
        in_src1   = AW'(s1);
        in_src2   = AW'(s2);
        rob_full  = full;
        rel_valid = relv;
        rel_preg  = PW'(relp);
        #1;
        zero   = (op == 1) && (s1 == s2);
        move   = (op == 2);
        needs  = (op == 0) || ((op == 1) && !zero);
        hasd   = (op != 3);
        xstall = full || (needs && (mfree.size() == 0));
        chk(stall === xstall, "R8", int'(stall), int'(xstall));
        pend = v && !xstall;
        if (pend) begin
            e_op = op; e_arch = d; e_zero = zero; e_move = move; e_needs = needs;
            e_p1 = mmap[s1];
            e_p2 = mmap[s2];
            e_po = hasd ? mmap[d] : ZP;
            e_recyc = 1'b0;
            if (needs) begin
                e_pd = mfree.pop_front();
                e_recyc = recyc[e_pd];
            end else if (move) begin
                e_pd = mmap[s1];
            end else begin
                e_pd = ZP;
            end
            e_exec  = !(zero || move);
            e_ready = zero || move;
            if ((needs || move) && (e_pd != ZP)) mcnt[e_pd]++;
            if (hasd) mmap[d] = e_pd;
            robq.push_back(e_po);
        end
        if (relv && (relp != ZP)) begin
            mcnt[relp]--;
            if (mcnt[relp] == 0) begin
                mfree.push_back(relp);
                recyc[relp] = 1'b1;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        for (int i = 0; i < NP; i++) begin
            mcnt[i]  = (i < NA) ? 1 : 0;
            recyc[i] = 1'b0;
        end
        for (int i = 0; i < NA; i++) mmap[i] = i;

        // reset: no output activity (R10)
        repeat (3) begin
            @(negedge clk);
            chk(out_valid === 1'b0, "R10", int'(out_valid), 0);
            chk(rob_alloc === 1'b0, "R10", int'(rob_alloc), 0);
        end
        rst_n = 1'b1;

        // seeding: stall high for NP-NA-1 cycles (R1)
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) chk(stall === 1'b1, "R1", int'(stall), 1);
        end while (stall && (n < 40));
        chk(n == NP - NA - 1, "R1", n, NP - NA - 1);
        for (int p = NA; p < NP - 1; p++) mfree.push_back(p);

        // directed: identity map, allocation, read-after-rename, idiom, move
        cyc(1, 3, 0, 3, 5, 0, 0);
        cyc(1, 0, 1, 2, 3, 0, 0);
        cyc(1, 3, 0, 1, 1, 0, 0);
        cyc(1, 1, 4, 5, 5, 0, 0);
        cyc(1, 2, 6, 1, 0, 0, 0);
        cyc(1, 1, 7, 6, 2, 0, 0);
        // drain the free list
        for (int k = 0; k < 6; k++) cyc(1, 0, k % NA, (k + 1) % NA, (k + 3) % NA, 0, 0);
        // empty: allocation stalls, eliminated and no-dest kinds proceed (R8)
        cyc(1, 0, 2, 3, 4, 0, 0);
        cyc(1, 1, 3, 4, 5, 0, 0);
        cyc(1, 1, 3, 2, 2, 0, 0);
        cyc(1, 2, 5, 1, 0, 0, 0);
        cyc(1, 3, 0, 6, 7, 0, 0);
        // reorder buffer full blocks every kind (R8)
        cyc(1, 2, 5, 1, 0, 1, 0);
        cyc(1, 3, 0, 1, 0, 1, 0);
        // commits refill; recycled registers come back in release order (R9)
        for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0, 0, 0, 1);
        for (int k = 0; k < 4; k++) cyc(1, 0, k, k + 1, k + 2, 0, 1);

        // near-exhaustive random traffic over the small configuration
        for (int k = 0; k < 4000; k++) begin
            int op, s1, s2;
            op = $urandom_range(0, 3);
            s1 = $urandom_range(0, NA - 1);
            s2 = ($urandom_range(0, 3) == 0) ? s1 : $urandom_range(0, NA - 1);
            cyc($urandom_range(0, 7) != 0, op, $urandom_range(0, NA - 1), s1, s2,
                $urandom_range(0, 7) == 0, $urandom_range(0, 3) != 0);
        end
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule